// File: doc/BRIEF.md
# PLL multiplier code converter

This block translates between a plain binary feedback multiplier (1 to 32768) and the scrambled code that a fractional PLL's divider register expects. The code is the position of a 15-bit linear-feedback sequence, not a binary count. The forward direction produces that code. It also derives two loop-bandwidth fields from the binary multiplier and packs all three into one 32-bit divider word. The reverse direction recovers the binary multiplier from a code.

A conversion starts with a one-cycle `start` pulse, and `dir` selects the direction. The block is iterative: it advances its shift register by one position per clock, so a conversion takes roughly `32769 - m` cycles. `busy` stays high until the result is posted. `done` then pulses for one cycle. Each result stays on its output until the next conversion in the same direction finishes.

The controller is a four-state machine:
- **IDLE**: waits for work. On `start` it moves to **FWD** when `dir`=0 and to **REV** when `dir`=1.
- **FWD**: steps the register until the step count is used up and the bandwidth divider is ready, then moves to **DONE**.
- **REV**: steps until the register holds the seed value or the counter reaches zero, then moves to **DONE**.
- **DONE**: raises `done` for one cycle and returns to **IDLE**.

Top module: `mcc_conv`

## Requirements
- R1: The forward conversion maps the special multipliers to fixed codes: multiplier 0 gives code 0, 1 gives 0x18003 and 2 gives 0x10003.
- R2: For any other multiplier m up to 32768, the forward conversion loads the shift register with 0x4000 and takes 32769-m steps. Each step shifts bits 14:1 down to 13:0 and writes bit0 XOR bit1 into bit 14. The code is the final register value.
- R3: The reverse conversion returns multiplier 1 for code 0x18003 and multiplier 2 for code 0x10003.
- R4: For any other code, the reverse conversion loads the 17-bit code and a counter of 32769. Each step moves bits 13:0 up to 14:1 and puts bit0 XOR bit14 into bit 0, and the counter decrements by one. Stepping stops when the register equals 0x4000 or the counter equals 0, and the counter is the result on `mult_out`. Code 0 therefore yields 0.
- R5: The proportional field is floor(m/2)+1 when m < 60 and 31 otherwise.
- R6: The integral field is 1 for m > 16384, 2 for 8192 < m ≤ 16384, 4 for 2048 < m ≤ 8192 and 8 for 501 ≤ m ≤ 2048.
- R7: The integral field is 4·ceil(1024/(m+9)) for 60 ≤ m ≤ 500 and (m AND 0x3C)+4 for m < 60. Both bandwidth fields use the binary multiplier.
- R8: `word_out` carries the code in bits 16:0, the proportional field in bits 21:17 and the integral field in bits 28:22. Bits 31:29 are zero.
- R9: `done` is high for exactly one cycle per conversion. `word_out` and `mult_out` change only at that cycle and hold their values otherwise.
- R10: `busy` rises on the clock after an accepted `start` and stays high through the `done` cycle. A `start` while `busy` is high is ignored and changes no result.
- R11: After reset `busy`, `done`, `mult_out` and `word_out` are all zero.
- R12: For a forward conversion of m ≥ 3 (m ≤ 32768), `done` is seen 32769-m+1 clock edges after the edge that accepted `start`. The special multipliers take one edge. A reverse conversion takes 32769 minus its result plus one edge, and a special code takes one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (accepted only when not busy) |
| dir | input | 1 | 0 = multiplier to code, 1 = code to multiplier |
| mult_in | input | 16 | Binary multiplier for the forward direction |
| code_in | input | 17 | Scrambled code for the reverse direction |
| busy | output | 1 | Conversion in progress, including the done cycle |
| done | output | 1 | One-cycle result strobe |
| mult_out | output | 16 | Last reverse-conversion result |
| word_out | output | 32 | Last forward-conversion packed divider word |

## Verification
A corrupted shift register or miscounted step total does not stay hidden: it gives a wrong code in the low 17 bits of `word_out`, or a multiplier off by the slip, at the `done` that ends that same conversion. A wrong step count also moves `done` itself, so the bench compares the exact edge of `done` with the expected step total, as well as the value. A bandwidth divider that ends early or late gives a wrong integral field for multipliers 60 to 500 on that conversion's word. A controller that accepts a second `start` shows up as an extra `done` or a disturbed held result.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int MULT_W   = 16;
    localparam int CODE_W   = 17;
    localparam int LFSR_W   = 15;
    localparam int WORD_W   = 32;
    localparam int PROP_W   = 5;
    localparam int INTG_W   = 7;
    localparam int PROP_LSB = CODE_W;
    localparam int INTG_LSB = PROP_LSB + PROP_W;
    localparam int MAX_MULT = 32768;
    localparam int REV_INIT = MAX_MULT + 1;
    localparam int PAD_W    = CODE_W - LFSR_W;
    localparam int DIV_NUM  = 1024;
    localparam int DIV_BIAS = 9;
    localparam int QUO_W    = 8;
    localparam int REM_W    = MULT_W + 2;
    localparam int LOW_LIM  = 60;
    localparam int MID_LIM  = 501;

    localparam logic [CODE_W-1:0] SEED = 17'h04000;
    localparam logic [CODE_W-1:0] FIX1 = 17'h18003;
    localparam logic [CODE_W-1:0] FIX2 = 17'h10003;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_REV,
        ST_DONE
    } cv_state_e;
endpackage

// File: rtl/mcc_lfsr.sv
module mcc_lfsr
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dir,
    input  logic              step_en,
    input  logic [MULT_W-1:0] mult_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] shreg,
    output logic [MULT_W-1:0] count,
    output logic              fwd_last,
    output logic              rev_last
);
    logic              dir_q;
    logic [CODE_W-1:0] fwd_preset;
    logic [MULT_W-1:0] fwd_steps;
    logic [CODE_W-1:0] fwd_next;
    logic [CODE_W-1:0] rev_next;

    always_comb begin
        unique case (mult_in)
            MULT_W'(0): fwd_preset = '0;
            MULT_W'(1): fwd_preset = FIX1;
            MULT_W'(2): fwd_preset = FIX2;
            default:    fwd_preset = SEED;
        endcase
        if (mult_in <= MULT_W'(2) || mult_in > MULT_W'(MAX_MULT))
            fwd_steps = '0;
        else
            fwd_steps = MULT_W'(REV_INIT) - mult_in;
    end

    assign fwd_next = {{PAD_W{1'b0}}, shreg[0] ^ shreg[1], shreg[LFSR_W-1:1]};
    assign rev_next = {{PAD_W{1'b0}}, shreg[LFSR_W-2:0], shreg[0] ^ shreg[LFSR_W-1]};

    assign fwd_last = (count == '0);
    assign rev_last = (shreg == SEED) || (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            shreg <= '0;
            count <= '0;
        end else if (load) begin
            dir_q <= dir;
            if (!dir) begin
                shreg <= fwd_preset;
                count <= fwd_steps;
            end else if (code_in == FIX1) begin
                shreg <= SEED;
                count <= MULT_W'(1);
            end else if (code_in == FIX2) begin
                shreg <= SEED;
                count <= MULT_W'(2);
            end else begin
                shreg <= code_in;
                count <= MULT_W'(REV_INIT);
            end
        end else if (step_en) begin
            if (!dir_q && !fwd_last) begin
                shreg <= fwd_next;
                count <= count - MULT_W'(1);
            end else if (dir_q && !rev_last) begin
                shreg <= rev_next;
                count <= count - MULT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mcc_bw.sv
module mcc_bw
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MULT_W-1:0] mult_in,
    output logic [PROP_W-1:0] prop,
    output logic [INTG_W-1:0] intg,
    output logic              ready
);
    logic [MULT_W-1:0]       m_q;
    logic signed [REM_W-1:0] rem_q;
    logic [QUO_W-1:0]        quo_q;
    logic                    in_mid;
    logic signed [REM_W-1:0] divisor;

    assign divisor = $signed({{(REM_W-MULT_W){1'b0}}, m_q} + REM_W'(DIV_BIAS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q   <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            m_q   <= mult_in;
            rem_q <= REM_W'(DIV_NUM);
            quo_q <= '0;
        end else if (rem_q > 0) begin
            rem_q <= rem_q - divisor;
            quo_q <= quo_q + QUO_W'(1);
        end
    end

    assign in_mid = (m_q >= MULT_W'(LOW_LIM)) && (m_q < MULT_W'(MID_LIM));
    assign ready  = !(in_mid && (rem_q > 0));

    always_comb begin
        if (m_q < MULT_W'(LOW_LIM))
            prop = PROP_W'((m_q >> 1) + MULT_W'(1));
        else
            prop = PROP_W'((1 << PROP_W) - 1);

        if (m_q > MULT_W'(16384))
            intg = INTG_W'(1);
        else if (m_q > MULT_W'(8192))
            intg = INTG_W'(2);
        else if (m_q > MULT_W'(2048))
            intg = INTG_W'(4);
        else if (m_q >= MULT_W'(MID_LIM))
            intg = INTG_W'(8);
        else if (in_mid)
            intg = INTG_W'({quo_q, 2'b00});
        else
            intg = INTG_W'((m_q & MULT_W'(8'h3c)) + MULT_W'(4));
    end
endmodule

// File: rtl/mcc_conv.sv
module mcc_conv
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [MULT_W-1:0] mult_in,
    input  logic [CODE_W-1:0] code_in,
    output logic              busy,
    output logic              done,
    output logic [MULT_W-1:0] mult_out,
    output logic [WORD_W-1:0] word_out
);
    cv_state_e         st_q, st_d;
    logic              take;
    logic              stepping;
    logic [CODE_W-1:0] shreg;
    logic [MULT_W-1:0] count;
    logic              fwd_last, rev_last;
    logic [PROP_W-1:0] prop;
    logic [INTG_W-1:0] intg;
    logic              bw_ready;
    logic              fwd_fin, rev_fin;
    logic [WORD_W-1:0] packed_w;

    assign take     = start && (st_q == ST_IDLE);
    assign stepping = (st_q == ST_FWD) || (st_q == ST_REV);
    assign fwd_fin  = (st_q == ST_FWD) && fwd_last && bw_ready;
    assign rev_fin  = (st_q == ST_REV) && rev_last;

    mcc_lfsr u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .dir      (dir),
        .step_en  (stepping),
        .mult_in  (mult_in),
        .code_in  (code_in),
        .shreg    (shreg),
        .count    (count),
        .fwd_last (fwd_last),
        .rev_last (rev_last)
    );

    mcc_bw u_bw (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take && !dir),
        .mult_in (mult_in),
        .prop    (prop),
        .intg    (intg),
        .ready   (bw_ready)
    );

    always_comb begin
        packed_w = '0;
        packed_w[CODE_W-1:0]          = shreg;
        packed_w[PROP_LSB +: PROP_W]  = prop;
        packed_w[INTG_LSB +: INTG_W]  = intg;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = dir ? ST_REV : ST_FWD;
            ST_FWD:  if (fwd_fin) st_d = ST_DONE;
            ST_REV:  if (rev_fin) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            mult_out <= '0;
        end else begin
            if (fwd_fin) word_out <= packed_w;
            if (rev_fin) mult_out <= count;
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_DONE);
endmodule

// File: rtl/mcc_conv_chk.sv
module mcc_conv_chk
    import mcc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [MULT_W-1:0] mult_out,
    input logic [WORD_W-1:0] word_out
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> done);

    // R9
    mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_out) |-> done);

    // R10
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8
    word_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_out[WORD_W-1:INTG_LSB+INTG_W] == '0);

    // R4
    mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mult_out <= MULT_W'(REV_INIT));
endmodule

bind mcc_conv mcc_conv_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mult_out (mult_out),
    .word_out (word_out)
);

// File: tb/mcc_conv_tb_top.sv
module mcc_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [15:0] mult_in = '0;
    logic [16:0] code_in = '0;
    logic        busy, done;
    logic [15:0] mult_out;
    logic [31:0] word_out;

    always #2 clk = ~clk;

    mcc_conv dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .mult_in(mult_in), .code_in(code_in), .busy(busy), .done(done),
        .mult_out(mult_out), .word_out(word_out)
    );

    typedef struct {
        bit    rev;
        int    val;
        int    due;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_code(int m);
        int x;
        if (m == 0) return 0;
        if (m == 1) return 'h18003;
        if (m == 2) return 'h10003;
        x = 'h4000;
        for (int i = m; i <= 32768; i++)
            x = (((x ^ (x >> 1)) & 1) << 14) | (x >> 1);
        return x;
    endfunction

    function automatic int m_prop(int m);
        return (m < 60) ? (m / 2 + 1) : 31;
    endfunction

    function automatic int m_intg(int m);
        if (m > 16384) return 1;
        if (m > 8192)  return 2;
        if (m > 2048)  return 4;
        if (m >= 501)  return 8;
        if (m >= 60)   return 4 * ((1024 + m + 8) / (m + 9));
        return (m & 'h3c) + 4;
    endfunction

    function automatic int m_word(int m);
        return m_code(m) | (m_prop(m) << 17) | (m_intg(m) << 22);
    endfunction

    function automatic int m_rev(int c);
        int x;
        int i;
        if (c == 'h18003) return 1;
        if (c == 'h10003) return 2;
        x = c;
        i = 32769;
        while (x != 'h4000 && i > 0) begin
            x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7fff);
            i--;
        end
        return i;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                int act;
                e = sb_q.pop_front();
                act = e.rev ? int'(mult_out) : int'(word_out);
                chk(act == e.val, e.req, e.rev ? "mult_out" : "word_out", act, e.val);
                // R12 latency
                chk(cyc == e.due, "R12", "done cycle", cyc, e.due);
            end
        end
    end

    task automatic launch(bit rv, int arg, int val, int steps, string req);
        exp_t e;
        e.rev = rv;
        e.val = val;
        e.due = cyc + steps + 2;
        e.req = req;
        sb_q.push_back(e);
        dir = rv;
        if (rv) code_in = arg[16:0];
        else    mult_in = arg[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fwd(int m, string req);
        launch(0, m, m_word(m), (m <= 2) ? 0 : 32769 - m, req);
        wait_done();
    endtask

    task automatic rev(int c, string req);
        int r;
        r = m_rev(c);
        launch(1, c, r, (c == 'h18003 || c == 'h10003) ? 0 : 32769 - r, req);
        wait_done();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        chk(0, "watchdog", "timeout", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy", busy, 0);
        chk(done == 1'b0, "R11", "done", done, 0);
        chk(word_out == '0, "R11", "word_out", word_out, 0);
        chk(mult_out == '0, "R11", "mult_out", mult_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        fwd(0, "R1 R5 R7 R8");
        // R9 done pulse is one cycle
        chk(done == 1'b0, "R9", "done after pulse", done, 0);
        fwd(1, "R1");
        fwd(2, "R1 R5");
        fwd(32768, "R2 R6");
        fwd(32767, "R2");
        fwd(32000, "R2 R6 R8");
        rev(m_code(32000), "R4");
        rev(m_code(32768), "R4");
        rev('h18003, "R3");
        rev('h10003, "R3");
        rev(0, "R4");
        rev(m_code(30000), "R4");

        // R10: start while busy is ignored
        launch(0, 32000, m_word(32000), 32769 - 32000, "R10");
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy during run", busy, 1);
        dir = 1'b1;
        code_in = 17'h18003;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(mult_out == 16'd30000, "R10", "mult_out after ignored start", mult_out, 30000);
        chk(busy == 1'b0, "R10", "busy after done", busy, 0);
        repeat (4) @(negedge clk);

        fwd(20000, "R6");
        fwd(3000, "R5 R6");
        fwd(100, "R5 R7");
        fwd(45, "R5 R7");

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R9", "pending results", sb_q.size(), 0);
        summary();
    end
endmodule